// File: doc/BRIEF.md
# Character LCD Write Strobe Sequencer

This block turns a stream of command and data bytes into write transfers on the parallel bus of a character LCD. A prescaler divides the fast system clock, nominally 50 MHz, down to a slow state tick. A small state machine advances one state per tick and drives the enable strobe. It keeps the data bus and the register-select line steady around each strobe. The read/write line is tied to write.

Bytes arrive through a ready/valid handshake. Two strobe shapes are available:
- **Two-state:** a low state, then a high state, giving 50% duty. At the default count of 62500 the tick is 800 Hz, so the strobe runs at 400 Hz with a 2.5 ms period.
- **Three-state:** setup low, strobe high, then hold low, giving one-third duty and a 3.75 ms period.

A debug rate select swaps the prescaler count for a much larger one, 5,000,000 by default. This gives a 10 Hz tick so the strobe can be watched by eye.

Top module: `lcd_strobe_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `lcd_e` is 0, `in_ready` is 1, `lcd_db` is 0 and `lcd_rs` is 0. Reset is synchronous and active high.
- R2: A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `lcd_db` shows `in_data` and `lcd_rs` shows `in_rs`, and the cycle starts with `lcd_e` low.
- R3: With `mode3`=0 at acceptance, a write cycle is TC clocks with `lcd_e` low, then TC clocks with `lcd_e` high, and then the block is idle.
- R4: With `mode3`=1 at acceptance, a write cycle is TC clocks low, then TC clocks high, then TC clocks low. `in_ready` is 1 only in the final clock of that last low state.
- R5: TC is NORM_TC when `dbg_rate`=0 at acceptance and DBG_TC when `dbg_rate`=1.
- R6: `lcd_db` and `lcd_rs` do not change while `lcd_e` is high, nor on the edge where `lcd_e` rises.
- R7: Changes on `mode3` and `dbg_rate` after acceptance have no effect on the cycle under way.
- R8: If `in_valid` is 1 in the final clock of a cycle, the next byte is taken on that edge. Its low state starts at once, with no idle clock between the cycles.
- R9: `lcd_rw` is always 0.
- R10: While `in_ready` is 0, the bus and register select hold their values, whatever `in_valid` and `in_data` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode3 | input | 1 | 1 selects the three-state strobe, 0 the two-state strobe; sampled at acceptance |
| dbg_rate | input | 1 | 1 selects the slow debug tick; sampled at acceptance |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | A byte can be taken this cycle |
| in_data | input | DW | Command or data byte |
| in_rs | input | 1 | Register select for the byte (0 command, 1 data) |
| lcd_e | output | 1 | LCD enable strobe |
| lcd_rs | output | 1 | LCD register select |
| lcd_rw | output | 1 | LCD read/write, held at 0 |
| lcd_db | output | DW | LCD data bus |

## Verification
Two events can fall in the same clock edge: the end of the last state of one write and the acceptance of the next byte. When they meet, the strobe falls and the bus changes on the same edge. To provoke this, the bench holds `in_valid` high with a second byte across the whole first write, so the handshake completes on the closing tick. The result is judged from the ports: the next strobe must rise exactly TC clocks after the previous one fell. The first byte must stay on the bus during the whole strobe, and the second byte must be on the bus when its own strobe rises.

// File: rtl/lcd_strobe_seq.sv
module lcd_strobe_seq #(
  parameter int unsigned NORM_TC = 62500,
  parameter int unsigned DBG_TC  = 5000000,
  parameter int unsigned DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode3,
  input  logic          dbg_rate,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_rs,
  output logic          lcd_e,
  output logic          lcd_rs,
  output logic          lcd_rw,
  output logic [DW-1:0] lcd_db
);

  localparam int unsigned MAX_TC = (NORM_TC > DBG_TC) ? NORM_TC : DBG_TC;
  localparam int CW = $clog2(MAX_TC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] tc_m1;
  logic          m3_q, dbg_q;
  logic          tick, last, take;

  assign tc_m1    = dbg_q ? CW'(DBG_TC - 1) : CW'(NORM_TC - 1);
  assign tick     = (st != ST_IDLE) && (cnt == tc_m1);
  assign last     = m3_q ? (st == ST_HOLD) : (st == ST_STROBE);
  assign in_ready = (st == ST_IDLE) || (last && tick);
  assign take     = in_valid && in_ready;
  assign lcd_e    = (st == ST_STROBE);
  assign lcd_rw   = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      m3_q   <= 1'b0;
      dbg_q  <= 1'b0;
      lcd_db <= '0;
      lcd_rs <= 1'b0;
    end else if (take) begin
      st     <= ST_SETUP;
      cnt    <= '0;
      m3_q   <= mode3;
      dbg_q  <= dbg_rate;
      lcd_db <= in_data;
      lcd_rs <= in_rs;
    end else if (tick) begin
      cnt <= '0;
      case (st)
        ST_SETUP:  st <= ST_STROBE;
        ST_STROBE: st <= last ? ST_IDLE : ST_HOLD;
        default:   st <= ST_IDLE;
      endcase
    end else if (st != ST_IDLE) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!lcd_e && in_ready && lcd_db == '0 && !lcd_rs));

  assert_take_starts_low_R2: assert property (@(posedge clk) disable iff (rst)
    take |=> (!lcd_e && !in_ready));

  assert_strobe_not_final_R4: assert property (@(posedge clk) disable iff (rst)
    (lcd_e && m3_q) |-> !in_ready);

  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (rst)
    lcd_e |-> ($stable(lcd_db) && $stable(lcd_rs)));

  assert_no_take_no_change_R10: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(lcd_db) && $stable(lcd_rs)));

endmodule

// File: tb/lcd_strobe_seq_bench.sv
module lcd_strobe_seq_bench;
  localparam int NTC = 3;
  localparam int DTC = 7;
  localparam int NV  = 8;
  // {mode3, dbg, flip, rs, exp_tc[3:0], data[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    16'h0338, 16'h9341, 16'h470C, 16'hD75A,
    16'h33FF, 16'hA300, 16'h67A5, 16'hF701
  };

  logic clk = 0, rst = 1;
  logic mode3 = 0, dbg_rate = 0, in_valid = 0, in_rs = 0;
  logic [7:0] in_data = 0;
  logic in_ready, lcd_e, lcd_rs, lcd_rw;
  logic [7:0] lcd_db;
  int total = 0, fails = 0, cyc = 0;

  lcd_strobe_seq #(.NORM_TC(NTC), .DBG_TC(DTC), .DW(8)) u_lcd_strobe_seq (
    .clk(clk), .rst(rst), .mode3(mode3), .dbg_rate(dbg_rate),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_rs(in_rs),
    .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_db(lcd_db));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; total++;
      $display("FAIL watchdog act=%0d exp<=20000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic m3, input logic dbg, input logic flip,
                          input logic rs, input logic [7:0] d,
                          output int lo, output int hi, output int post,
                          output int db_rise, output int rs_rise, output int rw_bad);
    @(negedge clk);
    mode3 = m3; dbg_rate = dbg; in_rs = rs; in_data = d; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    in_data = ~d;
    in_rs = ~rs;
    if (flip) begin mode3 = ~m3; dbg_rate = ~dbg; end
    lo = 0; hi = 0; post = 0; rw_bad = 0;
    while (!lcd_e) begin lo++; rw_bad += lcd_rw; @(negedge clk); end
    db_rise = lcd_db; rs_rise = lcd_rs;
    while (lcd_e) begin hi++; rw_bad += lcd_rw; @(negedge clk); end
    while (!in_ready) begin post++; @(negedge clk); end
  endtask

  initial begin
    int lo, hi, post, dbr, rsr, rwb, gap;
    repeat (3) @(negedge clk);
    chk("R1 e", lcd_e, 0);
    chk("R1 ready", in_ready, 1);
    chk("R1 db", lcd_db, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 after", {lcd_e, in_ready, lcd_rs}, 3'b010);
    chk("R9 rw", lcd_rw, 0);

    for (int i = 0; i < NV; i++) begin
      logic m3, dbg, fl, rs;
      int tc;
      logic [7:0] d;
      {m3, dbg, fl, rs} = VEC[i][15:12];
      tc = int'(VEC[i][11:8]);
      d = VEC[i][7:0];
      do_write(m3, dbg, fl, rs, d, lo, hi, post, dbr, rsr, rwb);
      chk(fl ? "R7 R5 low" : "R5 R3 low", lo, tc);
      chk(fl ? "R7 R5 high" : "R5 R3 high", hi, tc);
      chk(m3 ? "R4 hold" : "R3 end", post, m3 ? tc - 1 : 0);
      chk("R2 R6 db", dbr, int'(d));
      chk("R2 R6 rs", rsr, int'(rs));
      chk("R9 rw", rwb, 0);
    end

    // R8 and R10: back-to-back with in_data moving while busy
    @(negedge clk);
    mode3 = 0; dbg_rate = 0; in_rs = 1; in_data = 8'h3C; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_data = 8'hC3; in_rs = 0;
    while (!lcd_e) begin chk("R10 idle bus", lcd_db, 8'h3C); @(negedge clk); end
    while (lcd_e) begin chk("R10 strobe bus", lcd_db, 8'h3C); @(negedge clk); end
    in_valid = 0;
    gap = 0;
    while (!lcd_e) begin gap++; @(negedge clk); end
    chk("R8 gap", gap, NTC);
    chk("R8 db", lcd_db, 8'hC3);
    chk("R8 rs", lcd_rs, 0);
    while (!in_ready) @(negedge clk);

    // R1: reset in the middle of a strobe
    @(negedge clk);
    mode3 = 1; in_data = 8'h77; in_valid = 1;
    while (!lcd_e) @(negedge clk);
    in_valid = 0;
    rst = 1;
    @(negedge clk);
    chk("R1 mid e", lcd_e, 0);
    chk("R1 mid ready", in_ready, 1);
    chk("R1 mid db", lcd_db, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R1 stays idle", lcd_e, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule